// File: doc/BRIEF.md
# Residue-to-Binary Converter for the {2^n-1, 2^n, 2^(n+1)-1} Moduli

This block turns a number held as three residues back into an ordinary unsigned binary integer. The three moduli are 2^n-1, 2^n and 2^(n+1)-1, which are pairwise coprime. Their product M sets the range [0, M-1] of integers that the block can rebuild. For the default n = 7 the moduli are 127, 128 and 255, and M = 4145280. The block has no divider, no multiplier and no lookup memory. It works because of the special form of the moduli. Every modular inverse it needs reduces to a one-bit rotation, and every modular subtraction reduces to an end-around-carry add of a one's complement.

Let x2 be the residue modulo 2^n. The result is rebuilt as X = x2 + 2^n * Y, so the low n bits of X are x2 with no arithmetic at all. Y itself is assembled from two quantities:
- a difference modulo 2^n-1;
- a rotated difference modulo 2^(n+1)-1.

One further rotated modular difference and a plain binary combine then give Y. The datapath is a fixed five-register pipeline. A valid strobe travels alongside the data, and the block accepts a new triple every cycle.

Top module: `rns_to_bin`

## Requirements
- R1: For any in-range residue triple (resLo < 2^n-1, resMid < 2^n, resHi < 2^(n+1)-1), outValue is the unique X in [0, M-1] for which X mod (2^n-1) = resLo, X mod 2^n = resMid and X mod (2^(n+1)-1) = resHi.
- R2: outValid is high in exactly those cycles that come 5 clock edges after a cycle in which inValid was sampled high.
- R3: Whenever outValid is high, outValue is strictly less than M = (2^n-1) * 2^n * (2^(n+1)-1).
- R4: Triples presented on consecutive cycles each produce their own correct result on consecutive cycles, so the throughput is one triple per clock.
- R5: In any cycle where outValid is low, outValue keeps the value it last carried.
- R6: While rstN is low, outValid and outValue are both 0.
- R7: The boundary integers 0 and M-1 convert exactly.
- R8: A residue of all ones on resLo (n bits) or on resHi (n+1 bits) is accepted as another encoding of zero for that modulus, and gives the same result as the residue 0.
- R9: Every internal modular intermediate is kept in canonical form. It never holds the all-ones pattern of its width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Marks a residue triple to convert this cycle |
| resLo | input | N | Residue modulo 2^N-1 |
| resMid | input | N | Residue modulo 2^N |
| resHi | input | N+1 | Residue modulo 2^(N+1)-1 |
| outValid | output | 1 | Marks outValue as a fresh result |
| outValue | output | 3N+1 | Reconstructed unsigned integer |

## Verification
A triple driven before a rising edge is captured at that edge. Its integer appears after the fifth edge counted from capture, together with outValid. The bench drives inputs on falling edges and keeps the expected valid flag and value indexed by cycle number. At each falling edge it compares the outputs against the entry recorded five cycles earlier. In cycles with no expected result, it instead checks that outValid is low and that outValue still holds the last expected value. The expected integers come from a bench CRT computation that uses modular inverses found by search, so they are independent of the pipeline's rotation-based method.

// File: rtl/rns_to_bin_pkg.sv
package rns_to_bin_pkg;
  // number of register stages from capture to output
  localparam int STAGES = 5;

  // per-stage load strobes handed from control to datapath
  typedef struct packed {
    logic [STAGES-1:0] load;
  } stageCtl_t;
endpackage

// File: rtl/rns_to_bin_modadd.sv
// Adder modulo 2^W-1 with end-around carry and canonical (non all-ones) result.
module rns_to_bin_modadd #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  logic [W:0]   raw;
  logic [W-1:0] wrapped;

  always_comb begin
    raw     = {1'b0, a} + {1'b0, b};
    // the carry out has weight 2^W, which is 1 modulo 2^W-1
    wrapped = raw[W-1:0] + W'(raw[W]);
    // all ones is the second encoding of zero; fold it to zero
    sum     = (&wrapped) ? '0 : wrapped;
  end
endmodule

// File: rtl/rns_to_bin_ctrl.sv
module rns_to_bin_ctrl
  import rns_to_bin_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output stageCtl_t ctl,
  output logic      outValid
);
  localparam int CW = $clog2(STAGES + 1);

  logic [STAGES-1:0] vldPipe;
  logic [CW-1:0]     sinceRst;

  always_ff @(posedge clk) begin
    if (!rstN) vldPipe <= '0;
    else       vldPipe <= {vldPipe[STAGES-2:0], inValid};
  end

  always_comb begin
    ctl.load[0] = inValid;
    for (int i = 1; i < STAGES; i++) ctl.load[i] = vldPipe[i-1];
  end

  assign outValid = vldPipe[STAGES-1];

  // cycles since reset, used to keep the latency check inside its window
  always_ff @(posedge clk) begin
    if (!rstN)                        sinceRst <= '0;
    else if (sinceRst != CW'(STAGES)) sinceRst <= sinceRst + 1'b1;
  end

  // R2: a result flag appears exactly five edges after its input flag
  p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == CW'(STAGES)) |-> (outValid == $past(inValid, 5)));

  // R6: nothing valid straight out of reset
  p_reset_quiet_r6: assert property (@(posedge clk)
    $past(!rstN) |-> !outValid);
endmodule

// File: rtl/rns_to_bin_datapath.sv
module rns_to_bin_datapath
  import rns_to_bin_pkg::*;
#(
  parameter int N = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  stageCtl_t     ctl,
  input  logic [N-1:0]  resLo,
  input  logic [N-1:0]  resMid,
  input  logic [N:0]    resHi,
  output logic [3*N:0]  outValue
);
  localparam int WH = N + 1;      // width of the 2^(N+1)-1 channel
  localparam int YW = 2 * N + 1;  // width of the upper part Y
  localparam int OW = 3 * N + 1;  // output width

  // stage 0: captured inputs
  logic [N-1:0]  r0Lo, r0Mid;
  logic [WH-1:0] r0Hi;
  // stage 1: differences
  logic [N-1:0]  s1Y1, s1Mid;
  logic [WH-1:0] s1D3;
  // stage 2: correction factor
  logic [WH-1:0] s2K;
  logic [N-1:0]  s2Y1, s2Mid;
  // stage 3: upper part
  logic [YW-1:0] s3Y;
  logic [N-1:0]  s3Mid;
  // stage 4: output
  logic [OW-1:0] outReg;

  logic [N-1:0]  diffLo;
  logic [WH-1:0] diffHi, y3Rot, kSum, kRot;
  logic [YW-1:0] yVal;

  // x1 - x2 modulo 2^N-1 (inverse of 2^N is 1 there)
  rns_to_bin_modadd #(.W(N)) u_subLo (
    .a(r0Lo), .b(~r0Mid), .sum(diffLo)
  );

  // x3 - x2 modulo 2^(N+1)-1, x2 widened with a zero bit
  rns_to_bin_modadd #(.W(WH)) u_subHi (
    .a(r0Hi), .b(~{1'b0, r0Mid}), .sum(diffHi)
  );

  // times 2 (inverse of 2^N modulo 2^(N+1)-1) is a left rotation
  assign y3Rot = {s1D3[WH-2:0], s1D3[WH-1]};

  // Y1 - Y3 modulo 2^(N+1)-1, then times 2 again gives the inverse of -(2^N-1)
  rns_to_bin_modadd #(.W(WH)) u_subK (
    .a({1'b0, s1Y1}), .b(~y3Rot), .sum(kSum)
  );
  assign kRot = {kSum[WH-2:0], kSum[WH-1]};

  // Y = Y1 + (2^N-1)*k in plain binary
  assign yVal = {s2K, {N{1'b0}}} - YW'(s2K) + YW'(s2Y1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      r0Lo <= '0; r0Mid <= '0; r0Hi <= '0;
      s1Y1 <= '0; s1Mid <= '0; s1D3 <= '0;
      s2K  <= '0; s2Y1  <= '0; s2Mid <= '0;
      s3Y  <= '0; s3Mid <= '0;
      outReg <= '0;
    end else begin
      if (ctl.load[0]) begin
        r0Lo <= resLo; r0Mid <= resMid; r0Hi <= resHi;
      end
      if (ctl.load[1]) begin
        s1Y1 <= diffLo; s1D3 <= diffHi; s1Mid <= r0Mid;
      end
      if (ctl.load[2]) begin
        s2K <= kRot; s2Y1 <= s1Y1; s2Mid <= s1Mid;
      end
      if (ctl.load[3]) begin
        s3Y <= yVal; s3Mid <= s2Mid;
      end
      if (ctl.load[4]) begin
        // X = x2 + 2^N * Y is a concatenation
        outReg <= {s3Y, s3Mid};
      end
    end
  end

  assign outValue = outReg;

  // R9: intermediates stay canonical
  p_lo_canon_r9: assert property (@(posedge clk) disable iff (!rstN)
    s1Y1 != '1);
  p_hi_canon_r9: assert property (@(posedge clk) disable iff (!rstN)
    s1D3 != '1);
  p_k_canon_r9: assert property (@(posedge clk) disable iff (!rstN)
    s2K != '1);

  // R5: output register holds when its stage is not loaded
  p_out_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load[4] |=> $stable(outReg));
endmodule

// File: rtl/rns_to_bin.sv
module rns_to_bin
  import rns_to_bin_pkg::*;
#(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [N-1:0] resLo,
  input  logic [N-1:0] resMid,
  input  logic [N:0]   resHi,
  output logic         outValid,
  output logic [3*N:0] outValue
);
  localparam int OW = 3 * N + 1;
  localparam logic [OW:0] ONE = 1;
  // M = (2^N-1) * 2^N * (2^(N+1)-1), expanded into powers of two
  localparam logic [OW:0] MOD_M =
    (ONE << OW) - (ONE << (2 * N + 1)) - (ONE << (2 * N)) + (ONE << N);

  stageCtl_t ctl;

  rns_to_bin_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .ctl(ctl), .outValid(outValid)
  );

  rns_to_bin_datapath #(.N(N)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .resLo(resLo), .resMid(resMid), .resHi(resHi),
    .outValue(outValue)
  );

  // R3: every valid result lies inside the dynamic range
  p_out_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ({1'b0, outValue} < MOD_M));
endmodule

// File: tb/sim_rns_to_bin.sv
`timescale 1ns/1ps
module sim_rns_to_bin;
  localparam int N   = 7;
  localparam int LAT = 5;
  localparam int NC  = 2500;
  localparam longint M1 = 127, M2 = 128, M3 = 255;
  localparam longint MM = M1 * M2 * M3;

  logic          clk = 1'b0;
  logic          rstN;
  logic          inValid;
  logic [N-1:0]  resLo, resMid;
  logic [N:0]    resHi;
  logic          outValid;
  logic [3*N:0]  outValue;

  always #2 clk = ~clk;

  rns_to_bin #(.N(N)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .resLo(resLo), .resMid(resMid), .resHi(resHi),
    .outValid(outValid), .outValue(outValue)
  );

  int nRun = 0, nFail = 0;
  bit done = 1'b0;
  longint inv1, inv2, inv3;

  bit     expV [NC];
  longint expD [NC];
  string  expT [NC];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint findInv(input longint a, input longint m);
    for (longint t = 1; t < m; t++) if ((a * t) % m == 1) return t;
    return 0;
  endfunction

  // reference CRT with explicit inverses
  function automatic longint crtRef(input longint a, input longint b, input longint c);
    longint s;
    s = ((a % M1) * (MM / M1) % MM) * inv1 % MM;
    s = (s + ((b % M2) * (MM / M2) % MM) * inv2) % MM;
    s = (s + ((c % M3) * (MM / M3) % MM) * inv3) % MM;
    return s;
  endfunction

  task automatic drive(input bit v, input longint x, input bit loAlt, input bit hiAlt);
    inValid = v;
    resLo   = loAlt ? 7'h7f : N'(x % M1);
    resMid  = N'(x % M2);
    resHi   = hiAlt ? 8'hff : (N+1)'(x % M3);
  endtask

  initial begin
    void'($urandom(32'd4711));
    inv1 = findInv((MM / M1) % M1, M1);
    inv2 = findInv((MM / M2) % M2, M2);
    inv3 = findInv((MM / M3) % M3, M3);
    rstN = 1'b0;
    drive(1'b1, 12345, 1'b0, 1'b0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(outValid == 1'b0, "R6", outValid, 0);
    chk(outValue == '0, "R6", outValue, 0);
    rstN = 1'b1;
    begin
      longint lastD = 0;
      for (int c = 0; c < NC; c++) begin
        longint x;
        bit v, la, ha;
        string tg;
        if (c > 0) @(negedge clk);
        // outputs for the input driven LAT cycles ago
        if (c >= LAT) begin
          chk(outValid == expV[c-LAT], "R2", outValid, expV[c-LAT]);
          if (expV[c-LAT]) begin
            chk(outValue == expD[c-LAT], expT[c-LAT], outValue, expD[c-LAT]);
            chk(longint'(outValue) < MM, "R3", outValue, MM - 1);
            lastD = expD[c-LAT];
          end else begin
            chk(outValue == lastD, "R5", outValue, lastD);
          end
        end else begin
          chk(outValid == 1'b0, "R2", outValid, 0);
        end
        // stimulus for this cycle
        la = 1'b0; ha = 1'b0; tg = "R1";
        x = longint'($urandom) % MM;
        v = ($urandom % 4) != 0;
        if      (c == 2)  begin v = 1; x = 0;       tg = "R7"; end
        else if (c == 3)  begin v = 1; x = MM - 1;  tg = "R7"; end
        else if (c == 4 || c == 5) v = 0;
        else if (c == 6)  begin v = 1; x = M1 * 5;  la = 1; tg = "R8"; end
        else if (c == 7)  begin v = 1; x = M3 * 3;  ha = 1; tg = "R8"; end
        else if (c == 8)  begin v = 1; x = M1 * M3 * 2; la = 1; ha = 1; tg = "R8"; end
        else if (c == 9)  begin v = 1; x = MM - 1;  tg = "R7"; end
        else if (c == 10) begin v = 1; x = 0;       tg = "R7"; end
        else if (c >= 20 && c < 60) begin v = 1; tg = "R4"; end
        else if (c >= NC - LAT - 2) v = 0;
        drive(v, x, la, ha);
        expV[c] = v;
        expD[c] = crtRef(la ? M1 : x % M1, x % M2, ha ? M3 : x % M3);
        expT[c] = tg;
        // the reference must agree with the integer that produced the residues
        if (v && expD[c] != x) chk(1'b0, "R1", expD[c], x);
      end
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule